// File: doc/BRIEF.md
# Continuous-Conduction Retrigger Controller

This block switches an AC load on and keeps the power switch conducting without gaps, for resistive and inductive loads alike. Two window comparators watch the gate-to-terminal voltage of the switch. When that voltage sits inside their window, the switch is close to a current zero crossing and about to drop out, so the block fires another gate pulse. A third input follows the polarity of the mains voltage. Its level changes mark the voltage zero crossings. They are used to align the very first pulse and to time each half cycle.

Once enabled, the controller lets the mains settle for a fixed number of voltage crossings. It fires the first pulse on a crossing and then enters its on state, where every in-window event causes a retrigger. The comparator inputs are not looked at while a pulse is being driven, nor during a programmable settle interval that follows it. A window event that arrives too long after the last voltage crossing means the switch dropped out unexpectedly, and it raises an alarm. Too many retriggers inside one half cycle raise a fault. Either condition can optionally stop all gate drive.

Top module: `cc_retrig_ctrl`

## Requirements
- R1: During reset, and after reset while enable is low, gate_n is 1 and both alarm and fault are 0.
- R2: Each of cmp_low_in, cmp_high_in and vzc_in passes through a two-flop synchroniser. A level change that is present before rising edge k takes effect at edge k+2, so a pulse it causes drives gate_n low after the third edge counted from k.
- R3: After enable rises, the block arms. It fires no pulse until vzc_in has changed level ARM_EDGES times (default 5) while armed. The first pulse starts from that last change, with the timing of R2.
- R4: The gate output is active low. Every pulse that enable does not cut short lasts exactly max(pulse_len, MIN_PULSE) clock cycles, where MIN_PULSE is the 10 µs floor expressed in clocks.
- R5: In the on state, the window condition is cmp_low_in = 1 together with cmp_high_in = 0. No other combination of the two inputs starts a pulse.
- R6: The comparators are ignored while the gate is driven and for the next settle_len cycles. When the window is held continuously, gate_n stays high for settle_len+1 cycles between two pulses.
- R7: Pulses keep repeating while the window is held or entered again. Once the gate voltage stays outside the window, no further pulse is issued.
- R8: An in-window event in the on state sets alarm if it comes more than lag_max cycles after the latest vzc_in level change and not in the same cycle as a change. alarm is set on the same edge that handles the event and stays set until enable goes low.
- R9: Retriggers are counted per half cycle, and the count restarts at every vzc_in level change. The window event that would take the count above retrig_limit sets fault, which stays set until enable goes low.
- R10: If shut_en is 1 when an event sets alarm or fault, that event fires no pulse and no later pulse is issued until enable is cycled. If shut_en is 0, pulses continue.
- R11: When enable is sampled low, gate_n is high after the next edge and alarm and fault are cleared. When enable returns, arming starts again and needs a fresh count of crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Load on request; low stops all gate drive |
| shut_en | input | 1 | Stop gate drive when alarm or fault is raised |
| cmp_low_in | input | 1 | Comparator: gate voltage above the lower window edge (asynchronous) |
| cmp_high_in | input | 1 | Comparator: gate voltage above the upper window edge (asynchronous) |
| vzc_in | input | 1 | Mains polarity; each level change is a voltage zero crossing (asynchronous) |
| pulse_len | input | PW_W | Requested gate pulse length in clocks |
| settle_len | input | ST_W | Blanking cycles after each pulse |
| lag_max | input | LAG_W | Latest expected window event after a voltage crossing, in clocks |
| retrig_limit | input | RL_W | Retriggers allowed per half cycle |
| gate_n | output | 1 | Gate drive, active low |
| alarm | output | 1 | Sticky: unexpected drop out of conduction |
| fault | output | 1 | Sticky: retrigger count per half cycle exceeded |

## Verification
Most internal state reaches the ports quickly. A wrong arming count moves the first fall of gate_n by at least one whole half cycle. A wrong pulse or settle timer changes the low width or the high gap of the very next pulse. A half-cycle counter that fails to restart raises alarm or fault spuriously at the next window event. Because the bench compares gate_n, alarm and fault against its own model on every clock, any such error is reported in the first cycle where it becomes visible. Directed checks also measure latencies, pulse widths and gaps, which pin down off-by-one errors that the model would otherwise share.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PULSE,
        ST_SETTLE,
        ST_WATCH,
        ST_HALT
    } seq_state_t;

    // synchronised sense inputs, MSB first
    typedef struct packed {
        logic low_ok;      // above lower window edge
        logic high_trip;   // above upper window edge
        logic vline;       // mains polarity
    } sense_t;

    localparam int SENSE_W = $bits(sense_t);

    // outcome of one window event seen in the on state
    typedef struct packed {
        logic fire;
        logic unexpected;
        logic overrun;
    } trig_info_t;

    function automatic logic in_window(sense_t s);
        return s.low_ok && !s.high_trip;
    endfunction

    function automatic int unsigned eff_width(int unsigned req, int unsigned floor_v);
        return (req < floor_v) ? floor_v : req;
    endfunction

endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ccr_zc_track.sv
module ccr_zc_track #(
    parameter int LAG_W = 20,
    parameter int RL_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vline_s,
    input  logic             retrig_inc,
    output logic             vedge,
    output logic [LAG_W-1:0] since_q,
    output logic [RL_W-1:0]  rcnt_q
);

    localparam logic [LAG_W-1:0] SINCE_MAX = '1;
    localparam logic [RL_W-1:0]  RCNT_MAX  = '1;

    logic vline_d;

    assign vedge = vline_s ^ vline_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            vline_d <= 1'b0;
            since_q <= '0;
            rcnt_q  <= '0;
        end else begin
            vline_d <= vline_s;
            if (vedge)
                since_q <= '0;
            else if (since_q != SINCE_MAX)
                since_q <= since_q + 1'b1;
            if (vedge)
                rcnt_q <= RL_W'(retrig_inc);
            else if (retrig_inc && rcnt_q != RCNT_MAX)
                rcnt_q <= rcnt_q + 1'b1;
        end
    end

    AST_SINCE_RESTART: assert property (@(posedge clk) disable iff (rst)
        vedge |=> since_q == '0); // R8

    AST_RCNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (vedge && !retrig_inc) |=> rcnt_q == '0); // R9

endmodule

// File: rtl/ccr_seq.sv
module ccr_seq
    import ccr_pkg::*;
#(
    parameter int          PW_W      = 16,
    parameter int          ST_W      = 16,
    parameter int          LAG_W     = 20,
    parameter int          RL_W      = 4,
    parameter int unsigned MIN_PULSE = 2000,
    parameter int          ARM_EDGES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             shut_en,
    input  logic             win_now,
    input  logic             vedge,
    input  logic [LAG_W-1:0] since_q,
    input  logic [RL_W-1:0]  rcnt_q,
    input  logic [PW_W-1:0]  pulse_len,
    input  logic [ST_W-1:0]  settle_len,
    input  logic [LAG_W-1:0] lag_max,
    input  logic [RL_W-1:0]  retrig_limit,
    output logic             retrig_inc,
    output logic             gate_n,
    output logic             alarm,
    output logic             fault
);

    localparam int TMR_W = (PW_W > ST_W) ? PW_W : ST_W;
    localparam int ARM_W = (ARM_EDGES > 2) ? $clog2(ARM_EDGES) : 1;
    localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(ARM_EDGES - 1);

    seq_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic [ARM_W-1:0] arm_q, arm_d;
    logic             alarm_q, alarm_d;
    logic             fault_q, fault_d;

    trig_info_t       ev;
    logic [RL_W-1:0]  rc_now;
    logic [31:0]      pw_eff;
    logic [TMR_W-1:0] pw_load;
    logic [TMR_W-1:0] st_load;

    assign pw_eff  = eff_width(32'(pulse_len), MIN_PULSE);
    assign pw_load = TMR_W'(pw_eff - 32'd1);
    assign st_load = TMR_W'(settle_len) - 1'b1;
    assign rc_now  = vedge ? '0 : rcnt_q;

    always_comb begin
        ev.fire       = (state_q == ST_WATCH) && win_now;
        ev.unexpected = ev.fire && !vedge && (since_q > lag_max);
        ev.overrun    = ev.fire && (rc_now >= retrig_limit);
    end

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        arm_d   = arm_q;
        alarm_d = alarm_q;
        fault_d = fault_q;
        if (!enable) begin
            state_d = ST_IDLE;
            tmr_d   = '0;
            arm_d   = '0;
            alarm_d = 1'b0;
            fault_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_ARM;
                    arm_d   = '0;
                end
                ST_ARM: begin
                    if (vedge) begin
                        if (arm_q == ARM_LAST) begin
                            state_d = ST_PULSE;
                            tmr_d   = pw_load;
                        end else begin
                            arm_d = arm_q + 1'b1;
                        end
                    end
                end
                ST_PULSE: begin
                    if (tmr_q == '0) begin
                        if (settle_len == '0) begin
                            state_d = ST_WATCH;
                        end else begin
                            state_d = ST_SETTLE;
                            tmr_d   = st_load;
                        end
                    end else begin
                        tmr_d = tmr_q - 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_q == '0) state_d = ST_WATCH;
                    else             tmr_d   = tmr_q - 1'b1;
                end
                ST_WATCH: begin
                    if (ev.fire) begin
                        alarm_d = alarm_q | ev.unexpected;
                        fault_d = fault_q | ev.overrun;
                        if (shut_en && (ev.unexpected || ev.overrun)) begin
                            state_d = ST_HALT;
                        end else begin
                            state_d = ST_PULSE;
                            tmr_d   = pw_load;
                        end
                    end
                end
                ST_HALT: state_d = ST_HALT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            arm_q   <= '0;
            alarm_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            arm_q   <= arm_d;
            alarm_q <= alarm_d;
            fault_q <= fault_d;
        end
    end

    assign retrig_inc = ev.fire;
    assign gate_n     = (state_q != ST_PULSE);
    assign alarm      = alarm_q;
    assign fault      = fault_q;

    // low-time counter used only by the width assertion
    logic [TMR_W:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || gate_n)  low_run <= '0;
        else if (!(&low_run)) low_run <= low_run + 1'b1;
    end

    AST_GATE_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !enable |=> gate_n); // R11

    AST_PULSE_FLOOR: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_n) && $past(enable)) |-> 32'(low_run) >= MIN_PULSE); // R4

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (enable && alarm) |=> alarm); // R8

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (enable && fault) |=> fault); // R9

    AST_SHUTOFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (($rose(alarm) || $rose(fault)) && $past(shut_en)) |-> gate_n); // R10

endmodule

// File: rtl/cc_retrig_ctrl.sv
module cc_retrig_ctrl
    import ccr_pkg::*;
#(
    parameter int          PW_W      = 16,
    parameter int          ST_W      = 16,
    parameter int          LAG_W     = 20,
    parameter int          RL_W      = 4,
    parameter int unsigned MIN_PULSE = 2000,
    parameter int          ARM_EDGES = 5,
    parameter int          SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             shut_en,
    input  logic             cmp_low_in,
    input  logic             cmp_high_in,
    input  logic             vzc_in,
    input  logic [PW_W-1:0]  pulse_len,
    input  logic [ST_W-1:0]  settle_len,
    input  logic [LAG_W-1:0] lag_max,
    input  logic [RL_W-1:0]  retrig_limit,
    output logic             gate_n,
    output logic             alarm,
    output logic             fault
);

    sense_t           sense_raw, sense_s;
    logic             vedge;
    logic             retrig_inc;
    logic [LAG_W-1:0] since_q;
    logic [RL_W-1:0]  rcnt_q;

    assign sense_raw = '{low_ok: cmp_low_in, high_trip: cmp_high_in, vline: vzc_in};

    ccr_sync #(
        .WIDTH  (SENSE_W),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sense_raw),
        .q   (sense_s)
    );

    ccr_zc_track #(
        .LAG_W (LAG_W),
        .RL_W  (RL_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .vline_s    (sense_s.vline),
        .retrig_inc (retrig_inc),
        .vedge      (vedge),
        .since_q    (since_q),
        .rcnt_q     (rcnt_q)
    );

    ccr_seq #(
        .PW_W      (PW_W),
        .ST_W      (ST_W),
        .LAG_W     (LAG_W),
        .RL_W      (RL_W),
        .MIN_PULSE (MIN_PULSE),
        .ARM_EDGES (ARM_EDGES)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .shut_en      (shut_en),
        .win_now      (in_window(sense_s)),
        .vedge        (vedge),
        .since_q      (since_q),
        .rcnt_q       (rcnt_q),
        .pulse_len    (pulse_len),
        .settle_len   (settle_len),
        .lag_max      (lag_max),
        .retrig_limit (retrig_limit),
        .retrig_inc   (retrig_inc),
        .gate_n       (gate_n),
        .alarm        (alarm),
        .fault        (fault)
    );

endmodule

// File: tb/cc_retrig_ctrl_bench.sv
`timescale 1ns/1ps
module cc_retrig_ctrl_bench;

    localparam int MINP = 8;

    logic        clk = 1'b0;
    logic        rst, enable, shut_en, cmp_low, cmp_high, vzc;
    logic [15:0] pulse_len, settle_len;
    logic [19:0] lag_max;
    logic [3:0]  retrig_limit;
    logic        gate_n, alarm, fault;

    always #2.5 clk = ~clk;

    cc_retrig_ctrl #(.MIN_PULSE(MINP)) u_cc_retrig_ctrl (
        .clk(clk), .rst(rst), .enable(enable), .shut_en(shut_en),
        .cmp_low_in(cmp_low), .cmp_high_in(cmp_high), .vzc_in(vzc),
        .pulse_len(pulse_len), .settle_len(settle_len), .lag_max(lag_max),
        .retrig_limit(retrig_limit), .gate_n(gate_n), .alarm(alarm), .fault(fault)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // behavioural reference: mode 0 idle,1 arming,2 driving,3 blanking,4 on,5 stopped
    int m_mode = 0, m_left = 0, m_edges = 0, m_retrig = 0, m_age = 0;
    bit m_alarm = 0, m_fault = 0;
    bit pl[2], ph[2], pv[2];
    bit pv_last = 0;

    always @(posedge clk) begin
        bit win, ve, fire, late, over;
        int cnt, w;
        if (rst) begin
            m_mode = 0; m_left = 0; m_edges = 0; m_retrig = 0; m_age = 0;
            m_alarm = 0; m_fault = 0; pv_last = 0;
            pl = '{0, 0}; ph = '{0, 0}; pv = '{0, 0};
        end else begin
            win  = pl[1] && !ph[1];
            ve   = pv[1] != pv_last;
            fire = (m_mode == 4) && win;
            cnt  = ve ? 0 : m_retrig;
            late = fire && !ve && (m_age > int'(lag_max));
            over = fire && (cnt >= int'(retrig_limit));
            w    = (int'(pulse_len) < MINP) ? MINP : int'(pulse_len);
            if (!enable) begin
                m_mode = 0; m_edges = 0; m_alarm = 0; m_fault = 0;
            end else begin
                case (m_mode)
                    0: begin m_mode = 1; m_edges = 0; end
                    1: if (ve) begin
                        m_edges++;
                        if (m_edges == 5) begin m_mode = 2; m_left = w; end
                    end
                    2: begin
                        m_left--;
                        if (m_left == 0) begin
                            if (settle_len == 0) m_mode = 4;
                            else begin m_mode = 3; m_left = int'(settle_len); end
                        end
                    end
                    3: begin m_left--; if (m_left == 0) m_mode = 4; end
                    4: if (fire) begin
                        if (late) m_alarm = 1;
                        if (over) m_fault = 1;
                        if (shut_en && (late || over)) m_mode = 5;
                        else begin m_mode = 2; m_left = w; end
                    end
                    default: ;
                endcase
            end
            if (ve) m_retrig = fire ? 1 : 0;
            else if (fire && m_retrig < 15) m_retrig++;
            m_age = ve ? 0 : ((m_age < 1048575) ? m_age + 1 : m_age);
            pv_last = pv[1];
            pl[1] = pl[0]; pl[0] = cmp_low;
            ph[1] = ph[0]; ph[0] = cmp_high;
            pv[1] = pv[0]; pv[0] = vzc;
        end
    end

    // per-cycle comparison and pulse statistics
    int falls = 0, low_run = 0, hi_run = 0, last_width = 0, last_gap = 0;
    bit prev_g = 1;

    always @(negedge clk) begin
        if (!rst) begin
            chk(gate_n === (m_mode != 2), "R4 gate_n vs model", int'(gate_n), int'(m_mode != 2));
            chk(alarm === m_alarm, "R8 alarm vs model", int'(alarm), int'(m_alarm));
            chk(fault === m_fault, "R9 fault vs model", int'(fault), int'(m_fault));
            if (!gate_n) begin
                if (prev_g) begin falls++; last_gap = hi_run; end
                low_run++; hi_run = 0;
            end else begin
                if (!prev_g) last_width = low_run;
                low_run = 0; hi_run++;
            end
            prev_g = gate_n;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 20000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int f0;
        rst = 1; enable = 0; shut_en = 0; cmp_low = 0; cmp_high = 0; vzc = 0;
        pulse_len = 3; settle_len = 4; lag_max = 200; retrig_limit = 15;
        cyc(4);
        chk(gate_n == 1, "R1 gate idle in reset", gate_n, 1);
        rst = 0; cyc(2);
        chk(gate_n == 1, "R1 gate idle", gate_n, 1);
        chk(alarm == 0 && fault == 0, "R1 flags clear", alarm + fault, 0);

        // arming: four crossings do nothing
        enable = 1; cyc(3);
        for (int i = 0; i < 4; i++) begin vzc = !vzc; cyc(10); end
        chk(falls == 0, "R3 no pulse before fifth crossing", falls, 0);
        vzc = !vzc; cyc(2);
        chk(gate_n == 1, "R2 two-edge latency", gate_n, 1);
        cyc(1);
        chk(gate_n == 0, "R3 first pulse on fifth crossing", gate_n, 0);
        cyc(20);
        chk(last_width == MINP, "R4 width floor", last_width, MINP);
        chk(falls == 1, "R7 none outside window", falls, 1);

        // other comparator combinations
        cmp_low = 1; cmp_high = 1; cyc(15);
        cmp_low = 0; cmp_high = 1; cyc(15);
        cmp_high = 0; cyc(5);
        chk(falls == 1, "R5 only low=1 high=0 triggers", falls, 1);

        // held window: repeated pulses
        pulse_len = 12;
        vzc = !vzc; cyc(5);
        f0 = falls;
        cmp_low = 1; cyc(2);
        chk(gate_n == 1, "R2 comparator latency", gate_n, 1);
        cyc(1);
        chk(gate_n == 0, "R5 window starts pulse", gate_n, 0);
        cyc(40);
        chk(last_width == 12, "R4 programmed width", last_width, 12);
        chk(last_gap == 5, "R6 settle gap", last_gap, 5);
        cmp_low = 0; cyc(40);
        chk(falls == f0 + 3, "R7 pulses stop outside window", falls, f0 + 3);
        chk(alarm == 0, "R8 no alarm near crossing", alarm, 0);

        // blanking and re-entry
        vzc = !vzc; cyc(5);
        f0 = falls;
        cmp_low = 1; cyc(1); cmp_low = 0;
        cyc(4); cmp_low = 1; cyc(6); cmp_low = 0;
        cyc(40);
        chk(falls == f0 + 1, "R6 window during pulse ignored", falls, f0 + 1);
        cmp_low = 1; cyc(1); cmp_low = 0; cyc(30);
        chk(falls == f0 + 2, "R7 re-entry retriggers", falls, f0 + 2);

        // late window: alarm
        cyc(150);
        cmp_low = 1; cyc(1); cmp_low = 0; cyc(20);
        chk(alarm == 1, "R8 late window raises alarm", alarm, 1);
        chk(falls == f0 + 3, "R10 pulse continues without shut_en", falls, f0 + 3);
        chk(fault == 0, "R9 no fault within limit", fault, 0);
        cyc(10);
        chk(alarm == 1, "R8 alarm sticky", alarm, 1);

        // retrigger limit
        retrig_limit = 2;
        vzc = !vzc; cyc(5);
        f0 = falls;
        cmp_low = 1; cyc(60); cmp_low = 0; cyc(30);
        chk(fault == 1, "R9 limit exceeded", fault, 1);
        chk(falls - f0 >= 3, "R10 pulses continue without shut_en", falls - f0, 4);

        // disable mid pulse
        cmp_low = 1; cyc(1); cmp_low = 0; cyc(4);
        chk(gate_n == 0, "R11 pulse active before disable", gate_n, 0);
        enable = 0; cyc(1);
        chk(gate_n == 1, "R11 disable stops gate", gate_n, 1);
        chk(alarm == 0 && fault == 0, "R11 flags cleared", alarm + fault, 0);

        // re-arm needs fresh crossings
        retrig_limit = 15; enable = 1; cyc(3);
        f0 = falls;
        cmp_low = 1;
        for (int i = 0; i < 4; i++) begin vzc = !vzc; cyc(10); end
        chk(falls == f0, "R11 re-arm waits for crossings", falls, f0);
        cmp_low = 0; cyc(3);
        vzc = !vzc; cyc(3);
        chk(gate_n == 0, "R3 re-arm first pulse", gate_n, 0);
        cyc(30);

        // shut-off on fault
        shut_en = 1; retrig_limit = 0;
        vzc = !vzc; cyc(5);
        f0 = falls;
        cmp_low = 1; cyc(30);
        chk(falls == f0, "R10 shut-off suppresses pulse", falls, f0);
        chk(fault == 1, "R9 zero limit faults at once", fault, 1);
        chk(gate_n == 1, "R10 gate stays off", gate_n, 1);
        cmp_low = 0; cyc(10);
        chk(falls == f0, "R10 still halted", falls, f0);
        enable = 0; cyc(2);
        chk(fault == 0, "R11 fault cleared", fault, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule